// File: doc/BRIEF.md
# Multi-Block DMA Channel Sequencer

This block sequences one DMA channel through a transfer made of one or more blocks. Software programs the start addresses, the block length, a descriptor pointer, a block count and a next-block method for each side, then pulses a start strobe. The sequencer raises the channel enable and hands each block to an external data mover as a start pulse with source, destination and length. It waits for the mover's done pulse and then works out the parameters of the next block.

Each side picks its own next-block method. Contiguous continues from the previous block's end. Auto-reload returns to the address captured at start. Chaining takes the address from a four-word descriptor, which is read through a valid/ready memory port before every block. When the count runs out, or a fetched descriptor carries a zero next pointer, the channel clears its own enable and sets a sticky completion flag.

States: `ST_IDLE` (channel off), `ST_FETCH` (reading a descriptor), `ST_ISSUE` (one-cycle block start), `ST_WAIT` (block in flight). Transitions:
- IDLE→FETCH on start when a side chains.
- IDLE→ISSUE on start otherwise.
- FETCH→ISSUE after the fourth descriptor word.
- ISSUE→WAIT always.
- WAIT→FETCH or WAIT→ISSUE on done for a block that is not the last.
- WAIT→IDLE on done for the last block.

Top module: `dma_blk_seq`

## Requirements
- R1: After reset the outputs are as follows: `ch_en`, `blk_start`, `rd_valid`, `irq_flag` and `irq` are all 0.
- R2: With mode code 0 (contiguous) on a side, that side's next-block address is the previous block's address plus `blk_len`.
- R3: With mode code 1 (auto-reload) on a side, every block of that side starts at the address captured on the start strobe.
- R4: With mode code 2 (chaining) on either side, a descriptor is read before every block. It is four 32-bit words at pointer, pointer+4, pointer+8 and pointer+12, in this order: source address, destination address, block length, next pointer. The length word replaces `blk_len`, and each chaining side takes its address word. The first pointer is `cfg_next_ptr`.
- R5: When a chaining transfer fetches a descriptor with a next pointer of zero, the block it describes is the last one, even if the count has not run out.
- R6: A transfer ends after `cfg_blk_count` blocks; a count of 0 or 1 gives a single-block transfer.
- R7: The two sides apply their modes independently within one transfer. A non-chaining side in a chaining transfer keeps its own contiguous or reload rule, and the length it uses to advance is that of the block just finished.
- R8: On the done pulse of the last block, `ch_en` falls and `irq_flag` rises at the same clock edge, and no further block is started.
- R9: `irq_flag` stays set until a one-cycle `irq_clr` pulse clears it. A set and a clear in the same cycle leave the flag set. The output `irq` is `irq_flag` AND `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_start | input | 1 | Start strobe, taken while the channel is off |
| cfg_src_addr | input | 32 | Initial source address |
| cfg_dst_addr | input | 32 | Initial destination address |
| cfg_blk_len | input | 32 | Block length in bytes (non-chaining transfers) |
| cfg_next_ptr | input | 32 | First descriptor address |
| cfg_blk_count | input | 8 | Blocks per transfer |
| cfg_src_mode | input | 2 | Source next-block method: 0 contiguous, 1 reload, 2 chaining |
| cfg_dst_mode | input | 2 | Destination next-block method, same codes |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear strobe for the completion flag |
| ch_en | output | 1 | Channel enable |
| blk_start | output | 1 | One-cycle block start to the data mover |
| blk_src | output | 32 | Current block source address |
| blk_dst | output | 32 | Current block destination address |
| blk_len | output | 32 | Current block length |
| blk_done | input | 1 | Data mover block-complete pulse |
| rd_valid | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Descriptor word address |
| rd_ready | input | 1 | Read accepted; `rd_data` valid in that cycle |
| rd_data | input | 32 | Descriptor word |
| irq_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Masked completion interrupt |

## Verification
- **Block start.** A non-chaining block starts one cycle after the start strobe is taken, and one cycle after each done pulse. A chaining block starts one cycle after the fourth descriptor word is accepted. The bench monitor samples `blk_start` and its address and length fields at the falling edge, so it sees each block exactly in the cycle the field values are presented.
- **Completion.** `ch_en` and `irq_flag` change one edge after the final done pulse. The driver checks them only after it has seen `ch_en` low at a falling edge.
- **Flag clear.** The flag clears one edge after `irq_clr`, and the driver samples it at the following falling edge.
- **Scoreboard.** Expected block records are queued by the driver before each start. An unexpected extra block or a leftover record counts as a failure.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [1:0] {
        NB_CONTIG = 2'd0,
        NB_RELOAD = 2'd1,
        NB_CHAIN  = 2'd2
    } nb_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_ISSUE = 2'd2,
        ST_WAIT  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dma_side_addr.sv
module dma_side_addr
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_init,
    input  logic [AW-1:0] init_addr,
    input  logic          advance,
    input  logic [AW-1:0] cur_len,
    input  logic          desc_load,
    input  logic [AW-1:0] desc_addr,
    input  logic [1:0]    mode,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] init_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q <= '0;
            addr_q <= '0;
        end else if (load_init) begin
            init_q <= init_addr;
            addr_q <= init_addr;
        end else if (desc_load && mode == NB_CHAIN) begin
            addr_q <= desc_addr;
        end else if (advance) begin
            case (mode)
                NB_RELOAD: addr_q <= init_q;
                NB_CHAIN:  addr_q <= addr_q;
                default:   addr_q <= addr_q + cur_len;
            endcase
        end
    end

    assign addr = addr_q;

    AST_RELOAD_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load_init && mode == NB_RELOAD) |=> addr == $past(init_q)); // R3
    AST_CONTIG_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load_init && !desc_load && mode == NB_CONTIG)
            |=> addr == $past(addr) + $past(cur_len)); // R2
endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch #(
    parameter int AW = 32,
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_ptr,
    input  logic [AW-1:0] ptr_init,
    input  logic          go,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ready,
    input  logic [AW-1:0] rd_data,
    output logic [NW-1:0] word_stb,
    output logic          fetch_done,
    output logic          next_zero
);
    localparam int IW = $clog2(NW);
    localparam logic [IW-1:0] LAST = IW'(NW - 1);

    logic [IW-1:0] idx_q;
    logic [AW-1:0] ptr_q;
    logic          hs;

    assign rd_valid   = go;
    assign rd_addr    = ptr_q + AW'({idx_q, 2'b00});
    assign hs         = go && rd_ready;
    assign fetch_done = hs && idx_q == LAST;

    always_comb begin
        word_stb = '0;
        if (hs) word_stb[idx_q] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            ptr_q     <= '0;
            next_zero <= 1'b0;
        end else if (load_ptr) begin
            idx_q     <= '0;
            ptr_q     <= ptr_init;
            next_zero <= 1'b0;
        end else if (hs) begin
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
            if (idx_q == LAST) begin
                ptr_q     <= rd_data;
                next_zero <= (rd_data == '0);
            end
        end
    end

    AST_RD_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !load_ptr) |=> $stable(rd_addr)); // R4
endmodule

// File: rtl/dma_irq_flag.sv
module dma_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assign irq = flag && en;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag); // R9
endmodule

// File: rtl/dma_blk_seq.sv
module dma_blk_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ch_start,
    input  logic [AW-1:0] cfg_src_addr,
    input  logic [AW-1:0] cfg_dst_addr,
    input  logic [AW-1:0] cfg_blk_len,
    input  logic [AW-1:0] cfg_next_ptr,
    input  logic [CW-1:0] cfg_blk_count,
    input  logic [1:0]    cfg_src_mode,
    input  logic [1:0]    cfg_dst_mode,
    input  logic          irq_en,
    input  logic          irq_clr,
    output logic          ch_en,
    output logic          blk_start,
    output logic [AW-1:0] blk_src,
    output logic [AW-1:0] blk_dst,
    output logic [AW-1:0] blk_len,
    input  logic          blk_done,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ready,
    input  logic [AW-1:0] rd_data,
    output logic          irq_flag,
    output logic          irq
);
    localparam int NSIDE = 2;
    localparam int NWORD = 4;
    localparam int LEN_WORD = 2;

    seq_state_e state_q, state_d;
    logic [1:0]    mode_q [NSIDE];
    logic [1:0]    cfg_mode [NSIDE];
    logic [AW-1:0] cfg_addr [NSIDE];
    logic [AW-1:0] side_addr [NSIDE];
    logic [CW-1:0] count_q, done_cnt_q;
    logic [AW-1:0] len_q;
    logic [NWORD-1:0] word_stb;
    logic start_acc, fetch_go, fetch_done, next_zero;
    logic advance, finish, last_blk, chain_any, chain_cfg;

    assign cfg_mode[0] = cfg_src_mode;
    assign cfg_mode[1] = cfg_dst_mode;
    assign cfg_addr[0] = cfg_src_addr;
    assign cfg_addr[1] = cfg_dst_addr;

    assign chain_any = mode_q[0] == NB_CHAIN || mode_q[1] == NB_CHAIN;
    assign chain_cfg = cfg_src_mode == NB_CHAIN || cfg_dst_mode == NB_CHAIN;
    assign last_blk  = ({1'b0, done_cnt_q} + 1'b1 >= {1'b0, count_q})
                     || (chain_any && next_zero);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ch_start) state_d = chain_cfg ? ST_FETCH : ST_ISSUE;
            ST_FETCH: if (fetch_done) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (blk_done) begin
                          if (last_blk)       state_d = ST_IDLE;
                          else if (chain_any) state_d = ST_FETCH;
                          else                state_d = ST_ISSUE;
                      end
        endcase
    end

    // decoded controls
    always_comb begin
        start_acc = 1'b0;
        fetch_go  = 1'b0;
        blk_start = 1'b0;
        advance   = 1'b0;
        finish    = 1'b0;
        unique case (state_q)
            ST_IDLE:  start_acc = ch_start;
            ST_FETCH: fetch_go  = 1'b1;
            ST_ISSUE: blk_start = 1'b1;
            ST_WAIT:  begin
                          advance = blk_done && !last_blk;
                          finish  = blk_done && last_blk;
                      end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_en      <= 1'b0;
            count_q    <= '0;
            done_cnt_q <= '0;
            len_q      <= '0;
            mode_q[0]  <= NB_CONTIG;
            mode_q[1]  <= NB_CONTIG;
        end else begin
            if (start_acc) begin
                ch_en      <= 1'b1;
                count_q    <= cfg_blk_count;
                done_cnt_q <= '0;
                len_q      <= cfg_blk_len;
                mode_q[0]  <= cfg_src_mode;
                mode_q[1]  <= cfg_dst_mode;
            end else begin
                if (finish)  ch_en <= 1'b0;
                if (advance) done_cnt_q <= done_cnt_q + 1'b1;
                if (word_stb[LEN_WORD]) len_q <= rd_data;
            end
        end
    end

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dma_side_addr #(.AW(AW)) i_side (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_init (start_acc),
            .init_addr (cfg_addr[g]),
            .advance   (advance),
            .cur_len   (len_q),
            .desc_load (word_stb[g]),
            .desc_addr (rd_data),
            .mode      (mode_q[g]),
            .addr      (side_addr[g])
        );
    end

    dma_desc_fetch #(.AW(AW), .NW(NWORD)) i_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_ptr   (start_acc),
        .ptr_init   (cfg_next_ptr),
        .go         (fetch_go),
        .rd_valid   (rd_valid),
        .rd_addr    (rd_addr),
        .rd_ready   (rd_ready),
        .rd_data    (rd_data),
        .word_stb   (word_stb),
        .fetch_done (fetch_done),
        .next_zero  (next_zero)
    );

    dma_irq_flag i_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (finish),
        .clr   (irq_clr),
        .en    (irq_en),
        .flag  (irq_flag),
        .irq   (irq)
    );

    assign blk_src = side_addr[0];
    assign blk_dst = side_addr[1];
    assign blk_len = len_q;

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |-> ch_en); // R8
    AST_FETCH_ONLY_CHAINED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (ch_en && chain_any)); // R4
    AST_END_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ch_en) |-> irq_flag); // R8
    AST_NO_START_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !blk_start); // R8
endmodule

// File: tb/test_dma_blk_seq.sv
module test_dma_blk_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ch_start = 1'b0;
    logic [31:0] cfg_src_addr = '0, cfg_dst_addr = '0, cfg_blk_len = '0, cfg_next_ptr = '0;
    logic [7:0]  cfg_blk_count = '0;
    logic [1:0]  cfg_src_mode = '0, cfg_dst_mode = '0;
    logic        irq_en = 1'b0, irq_clr = 1'b0;
    logic        ch_en, blk_start, blk_done = 1'b0;
    logic [31:0] blk_src, blk_dst, blk_len;
    logic        rd_valid, rd_ready = 1'b0;
    logic [31:0] rd_addr, rd_data = '0;
    logic        irq_flag, irq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [95:0] exp_q[$];

    always #4 clk = ~clk;

    dma_blk_seq i_dma_blk_seq (
        .clk(clk), .rst_n(rst_n), .ch_start(ch_start),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_blk_len(cfg_blk_len), .cfg_next_ptr(cfg_next_ptr),
        .cfg_blk_count(cfg_blk_count), .cfg_src_mode(cfg_src_mode),
        .cfg_dst_mode(cfg_dst_mode), .irq_en(irq_en), .irq_clr(irq_clr),
        .ch_en(ch_en), .blk_start(blk_start), .blk_src(blk_src),
        .blk_dst(blk_dst), .blk_len(blk_len), .blk_done(blk_done),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_data(rd_data), .irq_flag(irq_flag), .irq(irq)
    );

    function automatic logic [31:0] desc_word(input logic [31:0] a);
        case (a)
            32'h100: return 32'h1000;  32'h104: return 32'h2000;
            32'h108: return 32'h20;    32'h10C: return 32'h110;
            32'h110: return 32'h1100;  32'h114: return 32'h2100;
            32'h118: return 32'h40;    32'h11C: return 32'h120;
            32'h120: return 32'h1200;  32'h124: return 32'h2200;
            32'h128: return 32'h8;     32'h12C: return 32'h0;
            default: return 32'hDEAD_BEEF;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory responder: ready on two cycles out of three
    always @(negedge clk) begin
        cyc <= cyc + 1;
        rd_ready <= (cyc % 3) != 0;
        rd_data  <= desc_word(rd_addr);
    end

    // monitor: pops expected blocks, answers with a done pulse
    initial begin
        int wait_n;
        wait_n = 0;
        forever begin
            @(negedge clk);
            blk_done = 1'b0;
            if (wait_n > 0) begin
                wait_n--;
                if (wait_n == 0) blk_done = 1'b1;
            end
            if (blk_start) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected block", {blk_src, blk_dst, blk_len}, '0);
                end else begin
                    logic [95:0] e;
                    e = exp_q.pop_front();
                    check({blk_src, blk_dst, blk_len} == e, "R2/R3/R4/R7", "block fields",
                          {blk_src, blk_dst, blk_len}, e);
                end
                wait_n = 3;
            end
        end
    end

    task automatic push(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l);
        exp_q.push_back({s, d, l});
    endtask

    task automatic run_xfer(input string req, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] l, input logic [31:0] p, input logic [7:0] n,
                            input logic [1:0] ms, input logic [1:0] md, input logic ie);
        cfg_src_addr = s; cfg_dst_addr = d; cfg_blk_len = l; cfg_next_ptr = p;
        cfg_blk_count = n; cfg_src_mode = ms; cfg_dst_mode = md; irq_en = ie;
        @(negedge clk); ch_start = 1'b1;
        @(negedge clk); ch_start = 1'b0;
        check(ch_en == 1'b1, "R8", "enable after start", ch_en, 1);
        while (ch_en) @(negedge clk);
        check(exp_q.size() == 0, req, "blocks left over", exp_q.size(), 0);
        check(irq_flag == 1'b1, "R8", "flag at end", irq_flag, 1);
        check(irq == ie, "R9", "masked irq", irq, ie);
        repeat (6) @(negedge clk);
        check(irq_flag == 1'b1, "R9", "flag sticky", irq_flag, 1);
        irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check(irq_flag == 1'b0 && irq == 1'b0, "R9", "flag cleared", {irq_flag, irq}, 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({ch_en, blk_start, rd_valid, irq_flag, irq} == 0, "R1", "reset outputs",
              {ch_en, blk_start, rd_valid, irq_flag, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 contiguous on both sides
        push(32'h4000, 32'h5000, 32'h10); push(32'h4010, 32'h5010, 32'h10);
        push(32'h4020, 32'h5020, 32'h10);
        run_xfer("R2", 32'h4000, 32'h5000, 32'h10, 32'h0, 8'd3, 2'd0, 2'd0, 1'b1);

        // R3 reload source, contiguous destination
        push(32'h4000, 32'h5000, 32'h10); push(32'h4000, 32'h5010, 32'h10);
        push(32'h4000, 32'h5020, 32'h10);
        run_xfer("R3", 32'h4000, 32'h5000, 32'h10, 32'h0, 8'd3, 2'd1, 2'd0, 1'b0);

        // R4/R5 chaining both sides, zero next pointer ends after 3 of 5
        push(32'h1000, 32'h2000, 32'h20); push(32'h1100, 32'h2100, 32'h40);
        push(32'h1200, 32'h2200, 32'h8);
        run_xfer("R5", 32'h0, 32'h0, 32'h99, 32'h100, 8'd5, 2'd2, 2'd2, 1'b1);

        // R6 count limit ends a chaining transfer first
        push(32'h1000, 32'h2000, 32'h20); push(32'h1100, 32'h2100, 32'h40);
        run_xfer("R6", 32'h0, 32'h0, 32'h99, 32'h100, 8'd2, 2'd2, 2'd2, 1'b1);

        // R7 source chains, destination contiguous
        push(32'h1000, 32'h8000, 32'h20); push(32'h1100, 32'h8020, 32'h40);
        push(32'h1200, 32'h8060, 32'h8);
        run_xfer("R7", 32'h0, 32'h8000, 32'h99, 32'h100, 8'd5, 2'd2, 2'd0, 1'b0);

        // R7 source chains, destination reloads
        push(32'h1000, 32'h8000, 32'h20); push(32'h1100, 32'h8000, 32'h40);
        push(32'h1200, 32'h8000, 32'h8);
        run_xfer("R7", 32'h0, 32'h8000, 32'h99, 32'h100, 8'd4, 2'd2, 2'd1, 1'b1);

        // R6 single-block transfers, counts 1 and 0
        push(32'h4000, 32'h5000, 32'h10);
        run_xfer("R6", 32'h4000, 32'h5000, 32'h10, 32'h0, 8'd1, 2'd0, 2'd1, 1'b1);
        push(32'h4400, 32'h5400, 32'h30);
        run_xfer("R6", 32'h4400, 32'h5400, 32'h30, 32'h0, 8'd0, 2'd0, 2'd0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule